// File: doc/BRIEF.md
# USB Control Endpoint Handshake Controller

This block governs the handshake decisions of a USB device's control endpoint. A CPU programs it through a small byte-wide register bus. A transaction engine on the other side reports decoded tokens (direction and device address) and single-cycle events: endpoint data sent, host ACK received, and data packet received. The block checks each token against its programmed function address and its device enable. It then decides whether to send endpoint data, return ACK, return NAK, or stay silent. It also keeps a status flag for each direction and raises an interrupt request from those flags.

A completed transfer sets the status flag for its direction. The flag holds off further traffic in that direction, with NAK, until software writes 1 to the matching clear bit. Software must also re-arm the direction through a separate enable bit, which the block drops by itself when a transfer finishes with ACK. Serial coding, CRC, packet identifier decoding and payload storage are all handled elsewhere.

The handshake sequencer is a five-state machine:
- IDLE waits for a token.
- IN_SEND waits for the data-sent pulse.
- IN_ACKWAIT waits for the host ACK.
- OUT_TAKE receives a packet that will be acknowledged.
- OUT_DROP receives a packet that will be refused.

Its transitions are:
- IDLE→IN_SEND: an armed IN token.
- IN_SEND→IN_ACKWAIT: data sent.
- IN_ACKWAIT→IDLE: host ACK, which completes the transmit.
- IDLE→OUT_TAKE: an armed OUT token.
- IDLE→OUT_DROP: an unarmed OUT token.
- OUT_TAKE→IDLE: packet received, answered with ACK.
- OUT_DROP→IDLE: packet received, answered with NAK.
- Any state→decode: an accepted token arriving in any state is decoded afresh and abandons the open transfer.

Top module: `ep0_handshake_ctrl`

## Requirements
- R1: Register index 0 holds the device enable in bit 7 and the 7-bit function address in bits 6:0. It reads back what was written and resets to 0x00.
- R2: A token is ignored, with no response and no change of state or flags, when the device enable is 0 or the token address differs from the function address.
- R3: An accepted IN token, with the transmit enable at 1 and the transmit flag at 0, gives response code DATA (2'b01) one cycle after the token.
- R4: Any other accepted IN token gives response code NAK (2'b11) one cycle after the token and leaves the machine idle.
- R5: The transmit flag sets only when a host ACK follows the data-sent pulse of an accepted IN transfer. The transmit enable clears in the same cycle. Both changes are visible one cycle after the ACK pulse.
- R6: An accepted OUT token, with the receive enable at 1 and the receive flag at 0, makes the next packet-received pulse give ACK (2'b10) one cycle later. In that same cycle the receive flag sets and the receive enable clears.
- R7: Any other accepted OUT token makes the next packet-received pulse give NAK (2'b11), and flags and enables are left unchanged.
- R8: Register index 1 reads the transmit flag in bit 7, the receive flag in bit 6, the transmit interrupt enable in bit 3 and the receive interrupt enable in bit 2. All other bits read 0, and the register resets to 0x00. A write loads bits 3:2. Writing 1 in bit 7 clears the transmit flag and writing 1 in bit 6 clears the receive flag; writing 0 there has no effect.
- R9: When a flag-setting event and a write-1-clear of that flag fall in the same cycle, the flag ends set.
- R10: The output irq is high exactly when (transmit flag and transmit interrupt enable) or (receive flag and receive interrupt enable).
- R11: Register index 2 holds the transmit enable in bit 1 and the receive enable in bit 0, and its other bits read 0. Register index 3 reads 0x00.
- R12: An accepted token that arrives while a transfer is open abandons that transfer and is decoded as if the machine were idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the indexed register (combinational) |
| tok_valid | input | 1 | One-cycle token pulse |
| tok_is_in | input | 1 | 1 = IN token, 0 = OUT token |
| tok_addr | input | 7 | Device address carried by the token |
| data_sent | input | 1 | Endpoint data has been sent |
| host_ack | input | 1 | Host ACK received |
| rx_pkt | input | 1 | Data packet received |
| resp_valid | output | 1 | A response code is presented this cycle |
| resp_kind | output | 2 | 01 DATA, 10 ACK, 11 NAK, 00 none |
| irq | output | 1 | Endpoint interrupt request |

## Verification
Assertions run on every cycle and check four things. A flag can only rise on a completion event, and a completion always leaves its flag set even when a clear collides with it. DATA is only ever offered to an armed, unflagged transmitter, and ACK only ever ends a receive that was accepted. An ignored token never produces a response. The bench's scenarios are the only way to show the full decision tables, because the assertions cannot enumerate them. These tables come from sweeps over device enable, address match, direction enable and flag state, plus the register layouts, the interrupt combinations and the abandonment of an open transfer.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

    localparam int FA_W  = 7;
    localparam int DW    = 8;
    localparam int RIDX_W = 2;

    localparam logic [RIDX_W-1:0] RIDX_ADDR = 2'd0;
    localparam logic [RIDX_W-1:0] RIDX_INT  = 2'd1;
    localparam logic [RIDX_W-1:0] RIDX_CTRL = 2'd2;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_DATA = 2'b01,
        RSP_ACK  = 2'b10,
        RSP_NAK  = 2'b11
    } resp_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IN_SEND,
        ST_IN_ACKWAIT,
        ST_OUT_TAKE,
        ST_OUT_DROP
    } hs_state_e;

endpackage

// File: rtl/ep0_tok_match.sv
module ep0_tok_match #(
    parameter int FA_W = 7
) (
    input  logic            dev_en,
    input  logic [FA_W-1:0] fn_addr,
    input  logic            tok_valid,
    input  logic [FA_W-1:0] tok_addr,
    output logic            tok_hit
);

    logic [FA_W-1:0] diff;

    // Bitwise difference, reduced; device enable gates acceptance.
    always_comb begin
        diff    = fn_addr ^ tok_addr;
        tok_hit = tok_valid && dev_en && (diff == '0);
    end

endmodule

// File: rtl/ep0_regfile.sv
module ep0_regfile
    import ep0_pkg::*;
#(
    parameter int FA_W = ep0_pkg::FA_W,
    parameter int DW   = ep0_pkg::DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              tx_done,
    input  logic              rx_done,
    output logic              dev_en,
    output logic [FA_W-1:0]   fn_addr,
    output logic              tx_flag,
    output logic              rx_flag,
    output logic              tx_ie,
    output logic              rx_ie,
    output logic              tx_en,
    output logic              rx_en
);

    localparam int B_TXF = DW - 1;
    localparam int B_RXF = DW - 2;
    localparam int B_TXIE = 3;
    localparam int B_RXIE = 2;
    localparam int B_TXEN = 1;
    localparam int B_RXEN = 0;

    logic wr_addr, wr_int, wr_ctrl;

    always_comb begin
        wr_addr = reg_wr && (reg_addr == RIDX_ADDR);
        wr_int  = reg_wr && (reg_addr == RIDX_INT);
        wr_ctrl = reg_wr && (reg_addr == RIDX_CTRL);
    end

    // Address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_en  <= 1'b0;
            fn_addr <= '0;
        end else if (wr_addr) begin
            dev_en  <= reg_wdata[DW-1];
            fn_addr <= reg_wdata[FA_W-1:0];
        end
    end

    // Interrupt enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ie <= 1'b0;
            rx_ie <= 1'b0;
        end else if (wr_int) begin
            tx_ie <= reg_wdata[B_TXIE];
            rx_ie <= reg_wdata[B_RXIE];
        end
    end

    // Status flags: hardware set outranks write-1 clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
        end else begin
            if (tx_done)
                tx_flag <= 1'b1;
            else if (wr_int && reg_wdata[B_TXF])
                tx_flag <= 1'b0;
            if (rx_done)
                rx_flag <= 1'b1;
            else if (wr_int && reg_wdata[B_RXF])
                rx_flag <= 1'b0;
        end
    end

    // Direction enables: self-clear on completion outranks software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else begin
            if (tx_done)
                tx_en <= 1'b0;
            else if (wr_ctrl)
                tx_en <= reg_wdata[B_TXEN];
            if (rx_done)
                rx_en <= 1'b0;
            else if (wr_ctrl)
                rx_en <= reg_wdata[B_RXEN];
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RIDX_ADDR: begin
                reg_rdata[DW-1]     = dev_en;
                reg_rdata[FA_W-1:0] = fn_addr;
            end
            RIDX_INT: begin
                reg_rdata[B_TXF]  = tx_flag;
                reg_rdata[B_RXF]  = rx_flag;
                reg_rdata[B_TXIE] = tx_ie;
                reg_rdata[B_RXIE] = rx_ie;
            end
            RIDX_CTRL: begin
                reg_rdata[B_TXEN] = tx_en;
                reg_rdata[B_RXEN] = rx_en;
            end
            default: reg_rdata = '0;
        endcase
    end

    a_r5_txflag_rise_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag) |-> $past(tx_done));
    a_r6_rxflag_rise_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(rx_done));
    a_r9_set_wins_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_done) |-> (tx_flag && !tx_en));
    a_r9_set_wins_rx: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_done) |-> (rx_flag && !rx_en));
    a_r8_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_int && reg_wdata[B_TXF] && !tx_done) |-> !tx_flag);

endmodule

// File: rtl/ep0_hs_fsm.sv
module ep0_hs_fsm
    import ep0_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tok_valid,
    input  logic       tok_hit,
    input  logic       tok_is_in,
    input  logic       data_sent,
    input  logic       host_ack,
    input  logic       rx_pkt,
    input  logic       tx_flag,
    input  logic       rx_flag,
    input  logic       tx_en,
    input  logic       rx_en,
    output logic       tx_done,
    output logic       rx_done,
    output logic       resp_valid,
    output logic [1:0] resp_kind
);

    hs_state_e st, st_nxt;
    resp_e     rsp_nxt, rsp_q;

    // Next-state and completion decode
    always_comb begin
        st_nxt  = st;
        rsp_nxt = RSP_NONE;
        tx_done = 1'b0;
        rx_done = 1'b0;
        if (tok_hit) begin
            if (tok_is_in) begin
                if (tx_en && !tx_flag) begin
                    st_nxt  = ST_IN_SEND;
                    rsp_nxt = RSP_DATA;
                end else begin
                    st_nxt  = ST_IDLE;
                    rsp_nxt = RSP_NAK;
                end
            end else begin
                st_nxt = (rx_en && !rx_flag) ? ST_OUT_TAKE : ST_OUT_DROP;
            end
        end else begin
            unique case (st)
                ST_IDLE: st_nxt = ST_IDLE;
                ST_IN_SEND: begin
                    if (data_sent)
                        st_nxt = ST_IN_ACKWAIT;
                end
                ST_IN_ACKWAIT: begin
                    if (host_ack) begin
                        tx_done = 1'b1;
                        st_nxt  = ST_IDLE;
                    end
                end
                ST_OUT_TAKE: begin
                    if (rx_pkt) begin
                        rx_done = 1'b1;
                        rsp_nxt = RSP_ACK;
                        st_nxt  = ST_IDLE;
                    end
                end
                ST_OUT_DROP: begin
                    if (rx_pkt) begin
                        rsp_nxt = RSP_NAK;
                        st_nxt  = ST_IDLE;
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rsp_q <= RSP_NONE;
        else
            rsp_q <= rsp_nxt;
    end

    always_comb begin
        resp_kind  = rsp_q;
        resp_valid = (rsp_q != RSP_NONE);
    end

    a_r3_data_only_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_kind == RSP_DATA) |-> $past(tx_en && !tx_flag));
    a_r6_ack_only_from_take: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_kind == RSP_ACK) |-> $past(st == ST_OUT_TAKE));
    a_r2_ignored_token_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tok_valid && !tok_hit && st == ST_IDLE) |-> !resp_valid);
    a_r5_done_after_ackwait: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (st == ST_IN_ACKWAIT));

endmodule

// File: rtl/ep0_handshake_ctrl.sv
module ep0_handshake_ctrl
    import ep0_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        tok_valid,
    input  logic        tok_is_in,
    input  logic [6:0]  tok_addr,
    input  logic        data_sent,
    input  logic        host_ack,
    input  logic        rx_pkt,
    output logic        resp_valid,
    output logic [1:0]  resp_kind,
    output logic        irq
);

    logic            dev_en;
    logic [FA_W-1:0] fn_addr;
    logic            tx_flag, rx_flag, tx_ie, rx_ie, tx_en, rx_en;
    logic            tx_done, rx_done, tok_hit;

    ep0_regfile #(.FA_W(FA_W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .tx_done(tx_done), .rx_done(rx_done),
        .dev_en(dev_en), .fn_addr(fn_addr),
        .tx_flag(tx_flag), .rx_flag(rx_flag),
        .tx_ie(tx_ie), .rx_ie(rx_ie),
        .tx_en(tx_en), .rx_en(rx_en)
    );

    ep0_tok_match #(.FA_W(FA_W)) u_match (
        .dev_en(dev_en), .fn_addr(fn_addr),
        .tok_valid(tok_valid), .tok_addr(tok_addr),
        .tok_hit(tok_hit)
    );

    ep0_hs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_hit(tok_hit), .tok_is_in(tok_is_in),
        .data_sent(data_sent), .host_ack(host_ack), .rx_pkt(rx_pkt),
        .tx_flag(tx_flag), .rx_flag(rx_flag),
        .tx_en(tx_en), .rx_en(rx_en),
        .tx_done(tx_done), .rx_done(rx_done),
        .resp_valid(resp_valid), .resp_kind(resp_kind)
    );

    always_comb begin
        irq = (tx_flag && tx_ie) || (rx_flag && rx_ie);
    end

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tx_flag || rx_flag));

endmodule

// File: tb/ep0_handshake_ctrl_bench.sv
module ep0_handshake_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tok_valid = 1'b0, tok_is_in = 1'b0;
    logic [6:0] tok_addr = 7'd0;
    logic       data_sent = 1'b0, host_ack = 1'b0, rx_pkt = 1'b0;
    logic       resp_valid;
    logic [1:0] resp_kind;
    logic       irq;

    localparam logic [1:0] K_NONE = 2'b00, K_DATA = 2'b01, K_ACK = 2'b10, K_NAK = 2'b11;
    localparam logic [6:0] FA = 7'h2B;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    ep0_handshake_ctrl u_ep0_handshake_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tok_valid(tok_valid), .tok_is_in(tok_is_in), .tok_addr(tok_addr),
        .data_sent(data_sent), .host_ack(host_ack), .rx_pkt(rx_pkt),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic token(input logic is_in, input logic [6:0] a);
        tok_valid = 1'b1; tok_is_in = is_in; tok_addr = a;
        tick();
        tok_valid = 1'b0;
    endtask

    task automatic p_sent();  data_sent = 1'b1; tick(); data_sent = 1'b0; endtask
    task automatic p_ack();   host_ack  = 1'b1; tick(); host_ack  = 1'b0; endtask
    task automatic p_rx();    rx_pkt    = 1'b1; tick(); rx_pkt    = 1'b0; endtask

    task automatic make_tx_flag();
        wr(2'd0, {1'b1, FA});
        wr(2'd2, 8'h02);
        token(1'b1, FA);
        p_sent();
        p_ack();
    endtask

    task automatic make_rx_flag();
        wr(2'd0, {1'b1, FA});
        wr(2'd2, 8'h01);
        token(1'b0, FA);
        p_rx();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // Reset state (R1, R8, R11)
        rd(2'd0, rv); chk("R1 reset addr reg", rv, 8'h00);
        rd(2'd1, rv); chk("R8 reset int reg", rv, 8'h00);
        rd(2'd2, rv); chk("R11 reset ctrl reg", rv, 8'h00);
        chk("R10 reset irq", {7'd0, irq}, 8'h00);
        chk("R3 reset resp", {6'd0, resp_kind}, 8'h00);

        // Register layouts
        wr(2'd0, 8'hA5); rd(2'd0, rv); chk("R1 addr readback", rv, 8'hA5);
        wr(2'd0, 8'h5A); rd(2'd0, rv); chk("R1 addr readback 2", rv, 8'h5A);
        wr(2'd2, 8'hFF); rd(2'd2, rv); chk("R11 ctrl mask", rv, 8'h03);
        wr(2'd3, 8'hFF); rd(2'd3, rv); chk("R11 index 3 zero", rv, 8'h00);
        wr(2'd1, 8'h3F); rd(2'd1, rv); chk("R8 int reserved zero", rv, 8'h0C);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        // IN sweep (R2, R3, R4, R5)
        for (int c = 0; c < 16; c++) begin
            logic dv, mt, en, fl;
            logic [1:0] ek;
            dv = c[3]; mt = c[2]; en = c[1]; fl = c[0];
            wr(2'd1, 8'hC0); wr(2'd2, 8'h00);
            if (fl) make_tx_flag();
            wr(2'd2, {6'd0, en, 1'b0});
            wr(2'd0, {dv, FA});
            token(1'b1, mt ? FA : (FA ^ 7'h01));
            if (!(dv && mt)) ek = K_NONE;
            else if (en && !fl) ek = K_DATA;
            else ek = K_NAK;
            chk(ek == K_NONE ? "R2 IN ignored" : (ek == K_DATA ? "R3 IN data" : "R4 IN nak"),
                {6'd0, resp_kind}, {6'd0, ek});
            if (ek == K_DATA) begin
                p_sent();
                rd(2'd1, rv); chk("R5 no flag before ack", rv, 8'h00);
                p_ack();
                rd(2'd1, rv); chk("R5 tx flag after ack", rv, 8'h80);
                rd(2'd2, rv); chk("R5 tx enable self-clear", rv, 8'h00);
            end else begin
                p_sent(); p_ack();
                rd(2'd1, rv); chk("R2 R4 tx flag unchanged", rv, {fl, 7'd0});
            end
        end

        // OUT sweep (R2, R6, R7)
        for (int c = 0; c < 16; c++) begin
            logic dv, mt, en, fl;
            logic [1:0] ek;
            dv = c[3]; mt = c[2]; en = c[1]; fl = c[0];
            wr(2'd1, 8'hC0); wr(2'd2, 8'h00);
            if (fl) make_rx_flag();
            wr(2'd2, {7'd0, en});
            wr(2'd0, {dv, FA});
            token(1'b0, mt ? FA : (FA ^ 7'h40));
            chk("R2 OUT token silent", {6'd0, resp_kind}, 8'h00);
            p_rx();
            if (!(dv && mt)) ek = K_NONE;
            else if (en && !fl) ek = K_ACK;
            else ek = K_NAK;
            chk(ek == K_NONE ? "R2 OUT ignored" : (ek == K_ACK ? "R6 OUT ack" : "R7 OUT nak"),
                {6'd0, resp_kind}, {6'd0, ek});
            rd(2'd1, rv);
            chk("R6 R7 rx flag", rv, {1'b0, (ek == K_ACK) ? 1'b1 : fl, 6'd0});
            rd(2'd2, rv);
            chk("R6 R7 rx enable", rv, {7'd0, (ek == K_ACK) ? 1'b0 : en});
        end

        // Interrupt combinations (R10) and clears (R8)
        wr(2'd1, 8'hC0);
        make_tx_flag();
        make_rx_flag();
        for (int m = 0; m < 16; m++) begin
            logic tf, rf;
            tf = m[3]; rf = m[2];
            wr(2'd1, {~tf, ~rf, 2'b00, m[1], m[0], 2'b00});
            rd(2'd1, rv);
            chk("R8 int readback", rv, {tf, rf, 2'b00, m[1], m[0], 2'b00});
            chk("R10 irq", {7'd0, irq}, {7'd0, (tf & m[1]) | (rf & m[0])});
            if (!tf || !rf) begin
                wr(2'd1, 8'hC0);
                make_tx_flag();
                make_rx_flag();
            end
        end
        wr(2'd1, 8'h00); rd(2'd1, rv); chk("R8 write zero keeps flags", rv, 8'hC0);
        wr(2'd1, 8'h80); rd(2'd1, rv); chk("R8 clear tx only", rv, 8'h40);
        wr(2'd1, 8'h40); rd(2'd1, rv); chk("R8 clear rx only", rv, 8'h00);

        // Set beats clear (R9)
        wr(2'd0, {1'b1, FA}); wr(2'd2, 8'h02);
        token(1'b1, FA); p_sent();
        host_ack = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h80;
        tick();
        host_ack = 1'b0; reg_wr = 1'b0;
        rd(2'd1, rv); chk("R9 set wins tx", rv, 8'h80);
        wr(2'd1, 8'hC0);
        wr(2'd2, 8'h01); token(1'b0, FA);
        rx_pkt = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h40;
        tick();
        rx_pkt = 1'b0; reg_wr = 1'b0;
        rd(2'd1, rv); chk("R9 set wins rx", rv, 8'h40);
        wr(2'd1, 8'hC0);

        // Abandon open transfer (R12)
        wr(2'd2, 8'h03);
        token(1'b1, FA);
        chk("R12 first IN data", {6'd0, resp_kind}, {6'd0, K_DATA});
        token(1'b0, FA);
        p_ack();
        rd(2'd1, rv); chk("R12 ack ignored after abandon", rv, 8'h00);
        p_rx();
        chk("R12 OUT ack", {6'd0, resp_kind}, {6'd0, K_ACK});
        rd(2'd1, rv); chk("R12 flags", rv, 8'h40);
        rd(2'd2, rv); chk("R12 tx enable kept", rv, 8'h02);

        finish_run();
    end

endmodule